// File: doc/BRIEF.md
# Cascaded Two-Stage Priority Interrupt Controller

This block merges sixteen interrupt request positions into a single interrupt line toward a processor. It is built from two eight-input priority stages. The secondary stage sits inside the block and feeds one input of the primary stage. Position 2 of the primary stage carries that cascade link. Position 0 is driven by an internal timer request and position 13 by a second internal source. That leaves thirteen positions fed from outside the block.

Each position can be programmed as edge-latched or level-following. Priority is fixed, and an in-service scheme blocks requests of equal or lower rank until software writes an end-of-interrupt. Software uses a small write port to program:
- the mask,
- the trigger mode,
- the two vector bases,
- the end-of-interrupt command.

The processor raises `inta` for one cycle to take the winning request. One cycle later it receives an 8-bit vector.

Top module: `irqc_pair`

## Requirements
- R1: After reset `int_out` and `vec_valid` are low, every position is masked, every position is edge-latched, the primary vector base is 0x08 and the secondary vector base is 0x70.
- R2: In edge mode, a rising input on an unmasked position raises `int_out` after the next clock edge. `int_out` stays high after the input falls, until that position is acknowledged.
- R3: In level mode (bit set by a write to address 1), the request follows the input. Dropping the input before acknowledge withdraws `int_out`. An input still high after end-of-interrupt requests again.
- R4: Address 0 holds the mask, with one bit per position and 1 meaning masked. An edge seen while masked is kept and shows up when the position is unmasked. Mask bit 2 hides every secondary position (8 to 15).
- R5: Priority is fixed, from highest to lowest: positions 0 and 1, then 8 through 15, then 3 through 7.
- R6: A write to address 2 sets the primary base from data bits 7:3 and the secondary base from bits 15:11. The returned vector is the base of the position's stage in bits 7:3 with the position number modulo 8 in bits 2:0.
- R7: Acknowledge marks the winner in service. Requests of equal or lower priority stay off `int_out` until end-of-interrupt, while higher ones still assert it. A serviced secondary position also marks position 2, which blocks all secondary positions and positions 3 to 7.
- R8: A write to address 3 is an end-of-interrupt. It clears the highest-priority in-service primary bit. When that bit is position 2, it also clears the secondary in-service bit, releasing both stages at once.
- R9: External inputs at positions 0, 2 and 13 have no effect. `timer_req` drives position 0 and `aux_req` drives position 13.
- R10: An acknowledge with no eligible request returns the primary base with bits 2:0 all ones and marks nothing in service.
- R11: `vec_valid` is high for exactly the one cycle after the cycle in which `inta` is high, and `vec_out` is valid then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 16 | External request inputs, one per position (0, 2, 13 unused) |
| timer_req | input | 1 | Internal timer request, position 0 |
| aux_req | input | 1 | Second internal request, position 13 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 trigger mode, 2 vector bases, 3 end-of-interrupt |
| wr_data | input | 16 | Write data |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | Vector strobe, one cycle |

## Verification
The bench builds the block with its defaults: eight positions per stage, the cascade on position 2, the timer on 0 and the auxiliary source on 13. With these values it can observe several things directly:
- a secondary position outranking primary 3 to 7 and being blocked through the cascade bit,
- a single end-of-interrupt releasing both stages,
- an ignored base-register field.

Each acknowledge pushes its expected vector into a queue, and a monitor compares every strobed vector in order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Fixed priority rank of a position; lower rank wins.
   // The cascade position shares the rank of the first secondary line so an
   // in-service cascade blocks the whole secondary stage.
   function automatic int line_rank(input int l, input int lp, input int casc);
      if (l == casc)      return casc;
      else if (l < casc)  return l;
      else if (l >= lp)   return casc + (l - lp);
      else                return l + lp - 1;
   endfunction

endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
   parameter int LP    = 8,
   parameter int CASC  = 2,
   parameter int TIMER = 0,
   parameter int AUX   = 13,
   localparam int TOTAL = 2 * LP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOTAL-1:0] ext_req,
   input  logic             timer_req,
   input  logic             aux_req,
   input  logic [TOTAL-1:0] level_mode,
   input  logic [TOTAL-1:0] clr,
   output logic [TOTAL-1:0] irr
);

   for (genvar g = 0; g < TOTAL; g++) begin : g_line
      if (g == CASC) begin : g_cascade
         logic unused_cas;
         assign unused_cas = ext_req[g] ^ level_mode[g] ^ clr[g];
         assign irr[g] = 1'b0;
      end else begin : g_req
         logic src, prev_q, req_q;
         if (g == TIMER) begin : g_tmr
            logic unused_ext;
            assign unused_ext = ext_req[g];
            assign src = timer_req;
         end else if (g == AUX) begin : g_aux
            logic unused_ext;
            assign unused_ext = ext_req[g];
            assign src = aux_req;
         end else begin : g_ext
            assign src = ext_req[g];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               req_q  <= 1'b0;
            end else begin
               prev_q <= src;
               if (level_mode[g])
                  req_q <= src;
               else
                  req_q <= (req_q & ~clr[g]) | (src & ~prev_q);
            end
         end
         assign irr[g] = req_q;
      end
   end

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
   import irqc_pkg::*;
#(
   parameter int LP   = 8,
   parameter int CASC = 2,
   localparam int TOTAL = 2 * LP,
   localparam int LN_W  = $clog2(TOTAL)
) (
   input  logic [TOTAL-1:0] irr,
   input  logic [TOTAL-1:0] mask,
   input  logic [TOTAL-1:0] isr,
   output logic             req,
   output logic [LN_W-1:0]  win
);

   int best_rk, blk_rk;

   always_comb begin
      best_rk = TOTAL - 1;
      blk_rk  = TOTAL - 1;
      win     = '0;
      for (int l = 0; l < LP; l++) begin
         if (isr[l] && line_rank(l, LP, CASC) < blk_rk)
            blk_rk = line_rank(l, LP, CASC);
      end
      for (int l = 0; l < TOTAL; l++) begin
         if (l != CASC && irr[l] && !mask[l] && (l < LP || !mask[CASC]) &&
             line_rank(l, LP, CASC) < best_rk) begin
            best_rk = line_rank(l, LP, CASC);
            win     = LN_W'(l);
         end
      end
      req = best_rk < blk_rk;
   end

endmodule

// File: rtl/irqc_service.sv
module irqc_service
   import irqc_pkg::*;
#(
   parameter int LP   = 8,
   parameter int CASC = 2,
   localparam int TOTAL = 2 * LP,
   localparam int LN_W  = $clog2(TOTAL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_fire,
   input  logic [LN_W-1:0]  win,
   input  logic             eoi,
   output logic [TOTAL-1:0] isr_q
);

   logic [TOTAL-1:0] isr_d;
   int top_ln, top_rk;
   logic sec_done;

   always_comb begin
      isr_d    = isr_q;
      top_ln   = -1;
      top_rk   = TOTAL;
      sec_done = 1'b0;
      if (eoi) begin
         for (int l = 0; l < LP; l++) begin
            if (isr_q[l] && line_rank(l, LP, CASC) < top_rk) begin
               top_rk = line_rank(l, LP, CASC);
               top_ln = l;
            end
         end
         for (int l = 0; l < LP; l++)
            if (l == top_ln) isr_d[l] = 1'b0;
         if (top_ln == CASC) begin
            for (int l = LP; l < TOTAL; l++) begin
               if (isr_q[l] && !sec_done) begin
                  isr_d[l] = 1'b0;
                  sec_done = 1'b1;
               end
            end
         end
      end
      if (ack_fire) begin
         isr_d[win] = 1'b1;
         if (int'(win) >= LP) isr_d[CASC] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

endmodule

// File: rtl/irqc_pair.sv
module irqc_pair #(
   parameter int          LP           = 8,
   parameter int          VEC_W        = 8,
   parameter int          CASC         = 2,
   parameter int          TIMER        = 0,
   parameter int          AUX          = 13,
   parameter logic [7:0]  PRI_RST_BASE = 8'h08,
   parameter logic [7:0]  SEC_RST_BASE = 8'h70,
   localparam int TOTAL = 2 * LP,
   localparam int LN_W  = $clog2(TOTAL),
   localparam int IDX_W = $clog2(LP),
   localparam int HI_W  = VEC_W - IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOTAL-1:0] ext_req,
   input  logic             timer_req,
   input  logic             aux_req,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [TOTAL-1:0] wr_data,
   input  logic             inta,
   output logic             int_out,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid
);

   if (LP != (1 << IDX_W))         begin : g_chk_lp   $error("LP must be a power of two");            end
   if (TOTAL != 2 * VEC_W)         begin : g_chk_w    $error("write data must hold both bases");      end
   if (CASC >= LP || TIMER >= LP)  begin : g_chk_pos  $error("cascade and timer must be primary");    end
   if (AUX < LP || AUX >= TOTAL)   begin : g_chk_aux  $error("aux source must be secondary");         end
   if (VEC_W > 8)                  begin : g_chk_vw   $error("reset bases limited to 8 bits");        end

   localparam logic [1:0] A_MASK = 2'd0, A_TRIG = 2'd1, A_BASE = 2'd2, A_EOI = 2'd3;

   logic [TOTAL-1:0] mask_q, level_q, irr_q, isr_q, clr;
   logic [HI_W-1:0]  pri_hi, sec_hi;
   logic             int_req, ack_fire, eoi;
   logic [LN_W-1:0]  win;
   logic             unused_wr;

   assign unused_wr = ^{wr_data[IDX_W-1:0], wr_data[VEC_W+IDX_W-1:VEC_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '1;
         level_q <= '0;
         pri_hi  <= PRI_RST_BASE[VEC_W-1:IDX_W];
         sec_hi  <= SEC_RST_BASE[VEC_W-1:IDX_W];
      end else if (wr_en) begin
         case (wr_addr)
            A_MASK: mask_q  <= wr_data;
            A_TRIG: level_q <= wr_data;
            A_BASE: begin
               pri_hi <= wr_data[VEC_W-1:IDX_W];
               sec_hi <= wr_data[2*VEC_W-1:VEC_W+IDX_W];
            end
            default: ;
         endcase
      end
   end

   assign eoi      = wr_en && (wr_addr == A_EOI);
   assign ack_fire = inta && int_req;
   assign clr      = ack_fire ? (TOTAL'(1) << win) : '0;

   irqc_req_bank #(.LP(LP), .CASC(CASC), .TIMER(TIMER), .AUX(AUX)) u_bank (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .timer_req(timer_req),
      .aux_req(aux_req), .level_mode(level_q), .clr(clr), .irr(irr_q)
   );

   irqc_resolver #(.LP(LP), .CASC(CASC)) u_pick (
      .irr(irr_q), .mask(mask_q), .isr(isr_q), .req(int_req), .win(win)
   );

   irqc_service #(.LP(LP), .CASC(CASC)) u_svc (
      .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .win(win), .eoi(eoi),
      .isr_q(isr_q)
   );

   assign int_out = int_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= inta;
         if (inta) begin
            if (!int_req)       vec_out <= {pri_hi, {IDX_W{1'b1}}};
            else if (win[IDX_W]) vec_out <= {sec_hi, win[IDX_W-1:0]};
            else                vec_out <= {pri_hi, win[IDX_W-1:0]};
         end
      end
   end

endmodule

// File: rtl/irqc_pair_chk.sv
module irqc_pair_chk #(
   parameter int LP    = 8,
   parameter int VEC_W = 8,
   parameter int CASC  = 2,
   localparam int TOTAL = 2 * LP,
   localparam int IDX_W = $clog2(LP),
   localparam int HI_W  = VEC_W - IDX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inta,
   input logic             int_out,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_out,
   input logic [TOTAL-1:0] irr,
   input logic [TOTAL-1:0] mask,
   input logic [TOTAL-1:0] isr,
   input logic [HI_W-1:0]  pri_hi
);

   p_strobe_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> vec_valid);

   p_strobe_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !inta |=> !vec_valid);

   p_unmasked_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> |(irr & ~mask));

   p_cascade_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|isr[TOTAL-1:LP]) |-> isr[CASC]);

   p_one_secondary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr[TOTAL-1:LP]));

   p_spurious_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !int_out) |=> (vec_out == {$past(pri_hi), {IDX_W{1'b1}}}));

   p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && int_out) |=> (|isr));

endmodule

bind irqc_pair irqc_pair_chk #(.LP(LP), .VEC_W(VEC_W), .CASC(CASC)) u_chk (
   .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
   .vec_valid(vec_valid), .vec_out(vec_out), .irr(irr_q), .mask(mask_q),
   .isr(isr_q), .pri_hi(pri_hi)
);

// File: tb/irqc_pair_test.sv
module irqc_pair_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_req = '0;
   logic        timer_req = 1'b0, aux_req = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        inta = 1'b0;
   logic        int_out, vec_valid;
   logic [7:0]  vec_out;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   irqc_pair uut (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .timer_req(timer_req),
      .aux_req(aux_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inta(inta), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // monitor: compare each strobed vector with the scoreboard
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) check("R11 unexpected vector", vec_out, 8'hxx);
         else check("R6 vector", vec_out, exp_q.pop_front());
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic eoi();
      wr(2'd3, 16'h0000);
   endtask

   task automatic ack(input logic [7:0] exp);
      exp_q.push_back(exp);
      inta = 1'b1;
      tick();
      inta = 1'b0;
      check("R11 strobe high", {7'd0, vec_valid}, 8'd1);
      tick();
      check("R11 strobe single", {7'd0, vec_valid}, 8'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 int_out", {7'd0, int_out}, 8'd0);
      check("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
      ack(8'h0F);                                  // R1 base, R10 spurious
      // R4 edge while masked is kept
      ext_req[3] = 1'b1; tick();
      check("R1 masked at reset", {7'd0, int_out}, 8'd0);
      wr(2'd0, 16'h0000);
      check("R4 latched edge appears", {7'd0, int_out}, 8'd1);
      ack(8'h0B);
      check("R7 in service", {7'd0, int_out}, 8'd0);
      eoi(); ext_req[3] = 1'b0;
      // R5 fixed priority, R7 nesting, R8 cascade release
      ext_req[1] = 1'b1; ext_req[5] = 1'b1; ext_req[9] = 1'b1; tick();
      check("R2 edge raises", {7'd0, int_out}, 8'd1);
      ack(8'h09);
      check("R7 lower blocked", {7'd0, int_out}, 8'd0);
      timer_req = 1'b1; tick(); timer_req = 1'b0;
      check("R7 higher preempts", {7'd0, int_out}, 8'd1);
      ack(8'h08);
      eoi();
      check("R8 clears top only", {7'd0, int_out}, 8'd0);
      eoi();
      check("R8 second release", {7'd0, int_out}, 8'd1);
      ack(8'h71);                                  // R5 secondary over line 5
      check("R7 cascade blocks", {7'd0, int_out}, 8'd0);
      ext_req[10] = 1'b1; tick();
      check("R7 secondary blocked", {7'd0, int_out}, 8'd0);
      eoi();
      check("R8 both stages freed", {7'd0, int_out}, 8'd1);
      ack(8'h72);
      eoi();
      ack(8'h0D);
      eoi();
      check("R5 all served", {7'd0, int_out}, 8'd0);
      ext_req = '0; tick();
      // R3 level vs R2 edge
      wr(2'd1, 16'h0010);
      ext_req[4] = 1'b1; tick();
      check("R3 level raises", {7'd0, int_out}, 8'd1);
      ext_req[4] = 1'b0; tick();
      check("R3 level withdraws", {7'd0, int_out}, 8'd0);
      ext_req[6] = 1'b1; tick(); ext_req[6] = 1'b0; tick();
      check("R2 edge sticky", {7'd0, int_out}, 8'd1);
      ack(8'h0E); eoi();
      ext_req[4] = 1'b1; tick();
      ack(8'h0C);
      check("R7 level in service", {7'd0, int_out}, 8'd0);
      eoi();
      check("R3 re-request", {7'd0, int_out}, 8'd1);
      ext_req[4] = 1'b0; tick();
      check("R3 level low", {7'd0, int_out}, 8'd0);
      // R4 cascade mask
      wr(2'd0, 16'h0004);
      ext_req[12] = 1'b1; tick();
      check("R4 cascade masked", {7'd0, int_out}, 8'd0);
      wr(2'd0, 16'h0000);
      check("R4 cascade unmasked", {7'd0, int_out}, 8'd1);
      ack(8'h74); eoi(); ext_req[12] = 1'b0;
      // R9 ignored external positions, internal sources
      ext_req[0] = 1'b1; ext_req[2] = 1'b1; ext_req[13] = 1'b1; tick();
      check("R9 ignored inputs", {7'd0, int_out}, 8'd0);
      ext_req = '0; tick();
      aux_req = 1'b1; tick();
      check("R9 aux source", {7'd0, int_out}, 8'd1);
      ack(8'h75); aux_req = 1'b0; eoi();
      // R6 base programming, R10 spurious without service
      wr(2'd2, 16'hA727);
      ext_req[7] = 1'b1; tick();
      ack(8'h27); eoi(); ext_req[7] = 1'b0;
      ext_req[15] = 1'b1; tick();
      ack(8'hA7); eoi(); ext_req[15] = 1'b0; tick();
      check("R10 idle", {7'd0, int_out}, 8'd0);
      ack(8'h27);
      ext_req[3] = 1'b1; tick();
      check("R10 nothing in service", {7'd0, int_out}, 8'd1);
      ack(8'h23); eoi(); ext_req[3] = 1'b0;
      tick();
      check("R11 scoreboard drained", 8'(exp_q.size()), 8'd0);
      finish_run();
   end

endmodule